// File: doc/BRIEF.md
# Presettable Cascadable Binary Down Counter

This block is one stage of a binary down counter with a parallel load. It is used to divide a pulse stream by an integer. A counting pulse arrives either as a rising edge on the count clock pin while the inhibit pin is low, or as a falling edge on the inhibit pin while the count clock pin is high. Each counting pulse lowers the stored value by one. A preset enable input loads the preset data word. The loaded value shows on the count output in the same system cycle as the enable, before any clock edge. A zero flag reports that the stored value is zero, gated by a cascade feedback input.

For a lone stage, cascade feedback is tied high and the zero flag drives preset enable. The stage then reloads N as soon as it reaches zero, and the flag pulses once every N counting pulses. For a wider divider, stages are chained with no extra gates:
- The lower stage's zero flag drives the upper stage's cascade feedback.
- Bit 3 of the lower stage's count drives the upper stage's count clock. That bit rises on the borrow from 0 to 15.
- The upper stage's zero flag drives every preset enable.

The raw count clock and inhibit pins are treated as asynchronous. Each passes through a synchronizer clocked by a free-running system clock, and edges are detected on the synchronized values.

Top module: `pdc_stage`

## Requirements
- R1: Each counting pulse lowers the 4-bit stored count by exactly one. The count wraps from 0 to 15. The new value is visible on count_o no later than the third system clock edge after the pin change that caused it.
- R2: A counting pulse is either a rising edge of cnt_clk_i while inhibit_i is low, or a falling edge of inhibit_i while cnt_clk_i is high. A falling edge of cnt_clk_i, a rising edge of inhibit_i, and a falling edge of inhibit_i while cnt_clk_i is low all leave the count unchanged.
- R3: While inhibit_i is held high, rising edges of cnt_clk_i do not change the count.
- R4: When a cnt_clk_i rising edge and an inhibit_i falling edge occur together, the count drops by one, not two.
- R5: While preset_en_i is high, count_o equals preset_i in the same system cycle, with no clock edge needed. The value is kept after preset_en_i falls. Counting pulses that occur while preset_en_i is high are ignored.
- R6: zero_o is high exactly when the stored count is 0 and cascade_fb_i is high.
- R7: After reset, the stored count is 0.
- R8: With cascade_fb_i high and zero_o driving preset_en_i, a stage preset to any N from 1 to 15 pulses zero_o once every N counting pulses. After each pulse the count is N again.
- R9: Two stages chained as described divide by 16*h+l, where h in 1..15 is the upper preset and l in 0..7 is the lower preset. The upper zero_o pulses once per 16*h+l counting pulses on the lower stage, and both stages reload afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | Raw count clock pin; a rising edge counts while inhibit is low |
| inhibit_i | input | 1 | Raw inhibit pin; blocks clock edges, and a falling edge counts while the clock is high |
| preset_en_i | input | 1 | Preset enable; loads preset_i at once |
| preset_i | input | 4 | Preset data word |
| cascade_fb_i | input | 1 | Qualifier for the zero flag; tie high on a lone stage |
| count_o | output | 4 | Current count (shows preset_i while preset_en_i is high) |
| zero_o | output | 1 | Stored count is zero and cascade_fb_i is high |

## Verification
The bench drives mixed sequences of pin activity and compares the count with a model after each one. These include clock edges under inhibit, inhibit falls with the clock high and with it low, and a clock rise together with an inhibit fall. A design that counts the wrong edge, ignores inhibit, or counts the combined event twice shows a count that drifts from the model. Directed cases cover the wrap from 0 to 15, the same-cycle visibility of a preset, and a clock pulse during a preset. A design that registered the preset first, or let that pulse through, would show a stale value or one less than the preset. Every divide ratio from 1 to 15 is checked, and two-stage chains are checked at the extremes 16 and 247 and at random values. Here a lost borrow, a reload that fires on a partial zero, or an off-by-one in the reload timing shows up as an early or late zero pulse.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // Previous synchronized pin levels used for edge detection
    typedef struct packed {
        logic clk_prev;
        logic inh_prev;
    } edge_state_t;

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int BITS   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [BITS-1:0] d_i,
    output logic [BITS-1:0] q_o
);

    logic [BITS-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pdc_event.sv
module pdc_event
    import pdc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clk_s_i,
    input  logic inh_s_i,
    output logic event_o
);

    edge_state_t st_d, st_q;
    logic        clk_rise, inh_fall;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = clk_s_i;
        st_d.inh_prev = inh_s_i;
        // Clock rising edge counts only while inhibit is low
        clk_rise      = clk_s_i & ~st_q.clk_prev & ~inh_s_i;
        // Inhibit falling edge counts only while the clock is high
        inh_fall      = ~inh_s_i & st_q.inh_prev & clk_s_i;
        // Both in one cycle still make a single count
        event_o       = clk_rise | inh_fall;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R3: inhibit held high over two samples never yields a count
    p_inhibit_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inh_s_i && st_q.inh_prev) |-> !event_o);

    // R2: a count needs a change on one of the two pins
    p_event_needs_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> ((clk_s_i != st_q.clk_prev) || (inh_s_i != st_q.inh_prev)));

endmodule

// File: rtl/pdc_core.sv
module pdc_core #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             event_i,
    input  logic             preset_en_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             cascade_fb_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_en_i) begin
            st_d.count = preset_i;
        end else if (event_i) begin
            st_d.count = st_q.count - WIDTH'(1);
        end
        // Preset shows at once; the register captures it on the next edge
        count_o = preset_en_i ? preset_i : st_q.count;
        // Zero decodes the stored state so a zero-to-preset loop settles
        zero_o  = (st_q.count == '0) && cascade_fb_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: preset loads the data word
    p_preset_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preset_en_i |=> (st_q.count == $past(preset_i)));

    // R1: one count event lowers the stored value by one
    p_decrement_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_en_i && event_i) |=> (st_q.count == $past(st_q.count) - WIDTH'(1)));

    // R3: no event and no preset keeps the value
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_en_i && !event_i) |=> $stable(st_q.count));

endmodule

// File: rtl/pdc_stage.sv
module pdc_stage #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cnt_clk_i,
    input  logic             inhibit_i,
    input  logic             preset_en_i,
    input  logic [WIDTH-1:0] preset_i,
    input  logic             cascade_fb_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);

    localparam int PINS = 2;

    logic [PINS-1:0] pins_raw, pins_s;
    logic            count_evt;

    assign pins_raw = {inhibit_i, cnt_clk_i};

    pdc_sync #(
        .BITS   (PINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_raw),
        .q_o    (pins_s)
    );

    pdc_event i_event (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clk_s_i (pins_s[0]),
        .inh_s_i (pins_s[1]),
        .event_o (count_evt)
    );

    pdc_core #(
        .WIDTH (WIDTH)
    ) i_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .event_i      (count_evt),
        .preset_en_i  (preset_en_i),
        .preset_i     (preset_i),
        .cascade_fb_i (cascade_fb_i),
        .count_o      (count_o),
        .zero_o       (zero_o)
    );

    // R6: the zero flag is never raised without cascade feedback
    p_zero_qualified_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o |-> cascade_fb_i);

endmodule

// File: tb/test_pdc_stage.sv
`timescale 1ns/1ps
module test_pdc_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_clk = 1'b0, raw_inh = 1'b0;
    logic       pe_drive = 1'b0, fb_mode = 1'b0, fb = 1'b1;
    logic [3:0] preset = 4'd0;
    logic [3:0] cnt;
    logic       zero, pe;

    logic       cas_clk = 1'b0;
    logic [3:0] cas_pre_lo = 4'd0, cas_pre_hi = 4'd1;
    logic [3:0] lo_cnt, hi_cnt;
    logic       lo_zero, hi_zero;

    int tests = 0, fails = 0;
    int zpulses = 0, hpulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign pe = fb_mode ? zero : pe_drive;

    pdc_stage i_pdc_stage (
        .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(raw_clk), .inhibit_i(raw_inh),
        .preset_en_i(pe), .preset_i(preset), .cascade_fb_i(fb),
        .count_o(cnt), .zero_o(zero));

    pdc_stage i_lo (
        .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cas_clk), .inhibit_i(1'b0),
        .preset_en_i(hi_zero), .preset_i(cas_pre_lo), .cascade_fb_i(1'b1),
        .count_o(lo_cnt), .zero_o(lo_zero));

    pdc_stage i_hi (
        .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(lo_cnt[3]), .inhibit_i(1'b0),
        .preset_en_i(hi_zero), .preset_i(cas_pre_hi), .cascade_fb_i(lo_zero),
        .count_o(hi_cnt), .zero_o(hi_zero));

    always @(negedge clk) begin
        if (zero)    zpulses++;
        if (hi_zero) hpulses++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Plain clock pulse with inhibit low: one count
    task automatic pulse_normal();
        raw_inh = 1'b0; wait_cyc(5);
        raw_clk = 1'b1; wait_cyc(5);
        raw_clk = 1'b0; wait_cyc(5);
    endtask

    // Clock pulse under inhibit, inhibit then falls with clock low: no count
    task automatic pulse_blocked();
        raw_inh = 1'b1; wait_cyc(5);
        raw_clk = 1'b1; wait_cyc(5);
        raw_clk = 1'b0; wait_cyc(5);
        raw_inh = 1'b0; wait_cyc(5);
    endtask

    // Inhibit falls while clock is high: one count
    task automatic pulse_inh_edge();
        raw_inh = 1'b1; wait_cyc(5);
        raw_clk = 1'b1; wait_cyc(5);
        raw_inh = 1'b0; wait_cyc(5);
        raw_clk = 1'b0; wait_cyc(5);
    endtask

    // Clock rise and inhibit fall together: one count
    task automatic pulse_both();
        raw_inh = 1'b1; wait_cyc(5);
        raw_clk = 1'b1; raw_inh = 1'b0; wait_cyc(5);
        raw_clk = 1'b0; wait_cyc(5);
    endtask

    task automatic load(input logic [3:0] v);
        preset = v; pe_drive = 1'b1; wait_cyc(2);
        pe_drive = 1'b0; wait_cyc(2);
    endtask

    task automatic cas_pulse();
        cas_clk = 1'b1; wait_cyc(5);
        cas_clk = 1'b0; wait_cyc(5);
    endtask

    function automatic logic [3:0] dec4(input logic [3:0] v);
        return v - 4'd1;
    endfunction

    initial begin
        #600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_cnt;
        int base, ops;
        int prev_n, h, l, n;
        void'($urandom(32'd7731));

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        // R7: reset state
        check("R7 reset count", cnt, 0);
        // R6: reset count zero with feedback high
        check("R6 zero at reset", zero, 1);

        // R1 wrap from 0 to 15
        load(4'd0);
        pulse_normal();
        check("R1 wrap", cnt, 15);

        // R1 timing: visible within three edges of the pin change
        load(4'd6);
        raw_clk = 1'b1;
        wait_cyc(3);
        check("R1 latency", cnt, 5);
        raw_clk = 1'b0; wait_cyc(5);

        // R3: inhibited clock edges
        load(4'd9);
        pulse_blocked();
        pulse_blocked();
        check("R3 inhibit blocks", cnt, 9);

        // R2: inhibit falling with clock high counts
        pulse_inh_edge();
        check("R2 inhibit edge", cnt, 8);

        // R4: simultaneous events count once
        pulse_both();
        check("R4 single count", cnt, 7);

        // R5: preset visible in same cycle, events ignored while set
        preset = 4'd11; pe_drive = 1'b1; #1;
        check("R5 immediate preset", cnt, 11);
        raw_clk = 1'b1; wait_cyc(5);
        raw_clk = 1'b0; wait_cyc(5);
        pe_drive = 1'b0; wait_cyc(2);
        check("R5 preset held, pulse ignored", cnt, 11);

        // R6: zero qualified by feedback
        load(4'd0);
        fb = 1'b0; wait_cyc(1);
        check("R6 zero gated low", zero, 0);
        fb = 1'b1; wait_cyc(1);
        check("R6 zero gated high", zero, 1);

        // R1 R2 R3 R4: random pin activity against model
        load(4'd3);
        exp_cnt = 4'd3;
        for (int i = 0; i < 60; i++) begin
            ops = $urandom_range(0, 3);
            case (ops)
                0: begin pulse_normal();   exp_cnt = dec4(exp_cnt); end
                1: begin pulse_blocked();  end
                2: begin pulse_inh_edge(); exp_cnt = dec4(exp_cnt); end
                default: begin pulse_both(); exp_cnt = dec4(exp_cnt); end
            endcase
            check($sformatf("R2 random op %0d kind %0d", i, ops), cnt, exp_cnt);
        end

        // R8: divide by N for every N
        for (int nn = 1; nn <= 15; nn++) begin
            load(4'(nn));
            base = zpulses;
            fb_mode = 1'b1;
            for (int k = 0; k < 2*nn - 1; k++) pulse_normal();
            check($sformatf("R8 N=%0d one pulse early", nn), zpulses - base, 1);
            pulse_normal();
            check($sformatf("R8 N=%0d two pulses", nn), zpulses - base, 2);
            check($sformatf("R8 N=%0d reloaded", nn), cnt, nn);
            fb_mode = 1'b0;
        end

        // R9: two-stage cascade; after reset it loaded hi=1, lo=0
        prev_n = 16;
        for (int t = 0; t < 5; t++) begin
            if (t == 0)      begin h = 1;  l = 0; end
            else if (t == 1) begin h = 15; l = 7; end
            else begin h = $urandom_range(1, 15); l = $urandom_range(0, 7); end
            n = 16*h + l;
            cas_pre_hi = 4'(h); cas_pre_lo = 4'(l);
            for (int k = 0; k < prev_n; k++) cas_pulse();
            base = hpulses;
            for (int k = 0; k < n - 1; k++) cas_pulse();
            check($sformatf("R9 N=%0d no early pulse", n), hpulses - base, 0);
            cas_pulse();
            check($sformatf("R9 N=%0d one pulse", n), hpulses - base, 1);
            for (int k = 0; k < n; k++) cas_pulse();
            check($sformatf("R9 N=%0d two pulses", n), hpulses - base, 2);
            check($sformatf("R9 N=%0d hi reload", n), hi_cnt, h);
            check($sformatf("R9 N=%0d lo reload", n), lo_cnt, l);
            prev_n = n;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule